// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block sits between a MAC-side byte stream and a single-port, byte-wide packet memory. It stores each incoming frame in a circular receive region. The region runs from a start address set by the host up to a fixed end address set by a parameter. Every stored frame is preceded by an 8-byte header: a 2-byte link to where the next frame will begin, then a 6-byte status word that carries the byte count, the MAC's status flags and an error flag. Frame bytes go to memory exactly as they arrive, including padding and CRC. The header is written last, once the length and the next-frame address are known. Before that point the frame is not visible, so a frame is either committed whole or not at all.

The block owns the head pointer, which marks where the next frame will start. It compares the space a frame needs against the tail pointer, which the host owns and moves forward as it consumes frames. A frame that would reach the tail is dropped. A frame that arrives while the 8-bit frame counter is saturated is also dropped. In both cases the head stays where it was. The host takes frames out by pulsing a decrement input.

Top module: `rxr_writer`

## Requirements
- R1: After reset the head, the start address and the frame count are all zero. A start-address write while no frame is in progress sets both the start address and the head to the written value with bit 0 cleared.
- R2: Frame bytes are written in arrival order, one per valid cycle, with the first byte at head+8. They are written unchanged.
- R3: After the last byte, the header is written at head+0..head+7 in eight consecutive cycles: bytes 0-1 hold the next-frame address, 2-3 the frame length, 4-5 the status input captured with the last byte (each field least significant byte first), byte 6 holds the error flag in bit 0, and byte 7 is zero.
- R4: When a frame commits, the head moves to head + 8 + length, rounded up to an even value and wrapped. The head is always even.
- R5: An address step past the end address continues at the start address. This applies to data, header and next-frame addresses.
- R6: The free room is the wrapped distance from head to tail, taken at the first byte. If 8 + length exceeds this room, frame_drop pulses on the first byte that does not fit. No byte is written at or past the tail, the rest of the frame is discarded, and the head and count do not change.
- R7: If the last byte arrives while the count is 255, frame_drop pulses with that byte, no header is written, and the head and count do not change.
- R8: A commit adds one to the count. pkt_dec subtracts one unless the count is zero. Both in the same cycle leave the count unchanged.
- R9: A frame whose first byte arrives while rx_enable is low is ignored: no write, no drop pulse, no head change.
- R10: Input bytes that arrive during the eight header-writing cycles are ignored, including any start flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable, sampled at frame start |
| cfg_start_we | input | 1 | Start-address write strobe |
| cfg_start | input | AW | New start address |
| tail | input | AW | Host tail pointer (even) |
| pkt_dec | input | 1 | Decrement the frame count |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Error flag, taken with the last byte |
| in_data | input | 8 | Stream byte |
| in_status | input | 16 | MAC status flags, taken with the last byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| head | output | AW | Current head pointer |
| pkt_count | output | 8 | Committed frames not yet released |
| frame_drop | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The count is changed by two agents. The commit in the last header cycle adds one, and the host's pkt_dec subtracts one. The bench places a decrement pulse exactly on the commit edge, counted eight edges after the edge that takes the last byte, and expects the count to stay the same while the head still advances. The same tension is tried at the limit: the count is pushed to 255, a further frame must drop, and a plain decrement must then bring the count back to 254.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_DISC = 2'd2,
    S_HDR  = 2'd3
  } rxr_state_e;

  localparam int unsigned HDR_BYTES = 8;
endpackage

// File: rtl/rxr_wrap_add.sv
module rxr_wrap_add #(
  parameter int unsigned AW = 15
) (
  input  logic [AW-1:0] base,
  input  logic [AW:0]   step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] sum
);
  logic [AW+1:0] raw;
  logic [AW+1:0] folded;

  always_comb begin
    raw    = {2'b00, base} + {1'b0, step};
    folded = raw - {2'b00, hi} - (AW+2)'(1) + {2'b00, lo};
    sum    = (raw > {2'b00, hi}) ? folded[AW-1:0] : raw[AW-1:0];
  end
endmodule

// File: rtl/rxr_free_space.sv
module rxr_free_space #(
  parameter int unsigned AW = 15
) (
  input  logic [AW-1:0] head,
  input  logic [AW-1:0] tail,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW:0]   room
);
  logic [AW:0] ring;

  always_comb begin
    ring = {1'b0, hi} - {1'b0, lo} + (AW+1)'(1);
    if (tail >= head) room = {1'b0, tail} - {1'b0, head};
    else              room = ring - ({1'b0, head} - {1'b0, tail});
  end
endmodule

// File: rtl/rxr_hdr_byte.sv
module rxr_hdr_byte #(
  parameter int unsigned AW = 15
) (
  input  logic [2:0]    idx,
  input  logic [AW-1:0] nxt,
  input  logic [15:0]   len,
  input  logic [15:0]   stat,
  input  logic          err,
  output logic [7:0]    byte_o
);
  logic [15:0] nxt16;

  always_comb begin
    nxt16 = 16'(nxt);
    unique case (idx)
      3'd0:    byte_o = nxt16[7:0];
      3'd1:    byte_o = nxt16[15:8];
      3'd2:    byte_o = len[7:0];
      3'd3:    byte_o = len[15:8];
      3'd4:    byte_o = stat[7:0];
      3'd5:    byte_o = stat[15:8];
      3'd6:    byte_o = {7'd0, err};
      default: byte_o = 8'd0;
    endcase
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int unsigned     AW       = 15,
  parameter logic [AW-1:0]   END_ADDR = AW'(24575),
  parameter int unsigned     CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          cfg_start_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] tail,
  input  logic          pkt_dec,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic [7:0]    in_data,
  input  logic [15:0]   in_status,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] head,
  output logic [CW-1:0] pkt_count,
  output logic          frame_drop
);
  localparam logic [AW:0] FIRST_OFF = (AW+1)'(HDR_BYTES);

  rxr_state_e    state_q, state_d;
  logic [AW-1:0] start_q, start_d, head_q, head_d;
  logic [AW:0]   off_q, off_d, dist_q, dist_d;
  logic [2:0]    hcnt_q, hcnt_d;
  logic [15:0]   stat_q, stat_d;
  logic          err_q, err_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic          in_idle, in_hdr, cfg_take, take_sof, take_dat, take;
  logic [AW:0]   room_now, off_cur, room_cur, step, pad_off;
  logic          fits, cnt_full, tail_drop, full_drop, commit, dec_ok;
  logic [AW-1:0] next_ptr;
  logic [15:0]   len16;
  logic [7:0]    hdr_byte;

  rxr_free_space #(.AW(AW)) u_room (
    .head(head_q), .tail(tail), .lo(start_q), .hi(END_ADDR), .room(room_now)
  );

  rxr_wrap_add #(.AW(AW)) u_addr (
    .base(head_q), .step(step), .lo(start_q), .hi(END_ADDR), .sum(mem_addr)
  );

  rxr_wrap_add #(.AW(AW)) u_next (
    .base(head_q), .step(pad_off), .lo(start_q), .hi(END_ADDR), .sum(next_ptr)
  );

  rxr_hdr_byte #(.AW(AW)) u_hdr (
    .idx(hcnt_q), .nxt(next_ptr), .len(len16), .stat(stat_q), .err(err_q),
    .byte_o(hdr_byte)
  );

  // stream acceptance, room and overflow decisions
  always_comb begin
    in_idle   = (state_q == S_IDLE);
    in_hdr    = (state_q == S_HDR);
    cfg_take  = cfg_start_we && in_idle;
    take_sof  = in_idle && in_valid && in_sof && rx_enable && !cfg_start_we;
    take_dat  = (state_q == S_DATA) && in_valid;
    take      = take_sof || take_dat;
    off_cur   = in_idle ? FIRST_OFF : off_q;
    room_cur  = in_idle ? room_now : dist_q;
    fits      = off_cur < room_cur;
    cnt_full  = (cnt_q == {CW{1'b1}});
    tail_drop = take && !fits;
    full_drop = take && fits && in_eof && cnt_full;
    commit    = in_hdr && (hcnt_q == 3'd7);
    dec_ok    = pkt_dec && (cnt_q != '0);
    step      = in_hdr ? (AW+1)'(hcnt_q) : off_cur;
    pad_off   = off_q + (AW+1)'(off_q[0]);
    len16     = 16'(off_q - FIRST_OFF);
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    start_d = start_q;
    head_d  = head_q;
    off_d   = off_q;
    dist_d  = dist_q;
    hcnt_d  = in_hdr ? hcnt_q + 3'd1 : 3'd0;
    stat_d  = stat_q;
    err_d   = err_q;
    cnt_d   = cnt_q + CW'(commit) - CW'(dec_ok);
    if (cfg_take) begin
      start_d = {cfg_start[AW-1:1], 1'b0};
      head_d  = {cfg_start[AW-1:1], 1'b0};
    end
    if (take_sof) dist_d = room_now;
    if (take && fits) off_d = off_cur + (AW+1)'(1);
    if (take && in_eof) begin
      stat_d = in_status;
      err_d  = in_err;
    end
    unique case (state_q)
      S_IDLE, S_DATA: begin
        if (take) begin
          if (!fits)       state_d = in_eof ? S_IDLE : S_DISC;
          else if (in_eof) state_d = cnt_full ? S_IDLE : S_HDR;
          else             state_d = S_DATA;
        end
      end
      S_DISC: if (in_valid && in_eof) state_d = S_IDLE;
      S_HDR: begin
        if (commit) begin
          state_d = S_IDLE;
          head_d  = next_ptr;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= '0;
      head_q  <= '0;
      off_q   <= '0;
      dist_q  <= '0;
      hcnt_q  <= '0;
      stat_q  <= '0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      cnt_q   <= cnt_d;
      if (cfg_take || commit) head_q <= head_d;
      if (cfg_take) start_q <= start_d;
      if (take) off_q <= off_d;
      if (take_sof) dist_q <= dist_d;
      if (take && in_eof) begin
        stat_q <= stat_d;
        err_q  <= err_d;
      end
    end
  end

  assign mem_we     = in_hdr || (take && fits);
  assign mem_wdata  = in_hdr ? hdr_byte : in_data;
  assign head       = head_q;
  assign pkt_count  = cnt_q;
  assign frame_drop = tail_drop || full_drop;

  p_head_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    head_q[0] == 1'b0);
  p_addr_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= start_q && mem_addr <= END_ADDR));
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA || state_q == S_DISC) |=> $stable(head_q));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CW{1'b1}}) |=> (cnt_q != '0));
  p_drop_no_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> (state_q != S_HDR));
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !rx_enable) |-> !mem_we);
endmodule

// File: tb/test_rxr_writer.sv
module test_rxr_writer;
  localparam int AW    = 7;
  localparam int ENDA  = 'h7B;
  localparam int START = 'h10;
  localparam int RING  = ENDA - START + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0, cfg_start_we = 1'b0, pkt_dec = 1'b0;
  logic [AW-1:0] cfg_start = '0, tail = '0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]    in_data = '0;
  logic [15:0]   in_status = '0;
  logic          mem_we, frame_drop;
  logic [AW-1:0] mem_addr, head;
  logic [7:0]    mem_wdata, pkt_count;

  int total = 0, bad = 0, nwr = 0, ndrop = 0;
  int exp_head = 0, exp_cnt = 0;
  logic [7:0] bmem [0:127];

  rxr_writer #(.AW(AW), .END_ADDR(AW'(ENDA)), .CW(8)) i_rxr_writer (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_start_we(cfg_start_we),
    .cfg_start(cfg_start), .tail(tail), .pkt_dec(pkt_dec), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
    .in_status(in_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .head(head), .pkt_count(pkt_count),
    .frame_drop(frame_drop)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      nwr <= nwr + 1;
    end
    if (rst_n && frame_drop) ndrop <= ndrop + 1;
  end

  function automatic int wadd(input int a, input int k);
    int s = a + k;
    if (s > ENDA) s = s - ENDA - 1 + START;
    return s;
  endfunction

  function automatic int wsub2(input int a);
    return (a >= START + 2) ? a - 2 : a - 2 + RING;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'(seed + j * 7);
  endfunction

  function automatic logic [15:0] stv(input int len);
    return 16'(len * 257) ^ 16'h1234;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int seed, input bit dec_at_commit);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (j == 0); in_eof = (j == len - 1);
      in_data = pat(seed, j); in_err = len[0]; in_status = stv(len);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (7) @(negedge clk);
    if (dec_at_commit) pkt_dec = 1'b1;
    @(negedge clk);
    pkt_dec = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_stored(input int h0, input int len, input int seed);
    int nx, ml, bad_data;
    bit wrapped;
    nx = wadd(h0, 8 + len + ((8 + len) % 2));
    ml = 0;
    ml += (bmem[wadd(h0, 0)] != 8'(nx));
    ml += (bmem[wadd(h0, 1)] != 8'(nx >> 8));
    ml += (bmem[wadd(h0, 2)] != 8'(len));
    ml += (bmem[wadd(h0, 3)] != 8'(len >> 8));
    ml += (bmem[wadd(h0, 4)] != stv(len)[7:0]);
    ml += (bmem[wadd(h0, 5)] != stv(len)[15:8]);
    ml += (bmem[wadd(h0, 6)] != {7'd0, len[0]});
    ml += (bmem[wadd(h0, 7)] != 8'd0);
    chk(ml == 0, "R3 header bytes", ml, 0);
    bad_data = 0;
    wrapped = 1'b0;
    for (int j = 0; j < len; j++) begin
      if (bmem[wadd(h0, 8 + j)] != pat(seed, j)) bad_data++;
      if (wadd(h0, 8 + j) < h0) wrapped = 1'b1;
    end
    if (wrapped) chk(bad_data == 0, "R5 wrapped data", bad_data, 0);
    else         chk(bad_data == 0, "R2 data bytes", bad_data, 0);
    exp_head = nx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h0, w0, d0, c0, len, dd;
    bit expd;
    for (int i = 0; i < 128; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(head == '0 && pkt_count == '0 && !mem_we, "R1 reset state", int'(head), 0);

    cfg_start = AW'(START + 1); cfg_start_we = 1'b1;
    @(negedge clk); cfg_start_we = 1'b0;
    chk(int'(head) == START, "R1 start write sets head", int'(head), START);
    exp_head = START;
    rx_enable = 1'b1;

    // length sweep with maximum room
    for (int l = 1; l <= 60; l++) begin
      tail = AW'(wsub2(exp_head));
      h0 = exp_head;
      send(l, l * 13, 1'b0);
      check_stored(h0, l, l * 13);
      exp_cnt++;
      chk(int'(head) == exp_head, "R4 head after commit", int'(head), exp_head);
      chk(int'(pkt_count) == exp_cnt, "R8 count increment", int'(pkt_count), exp_cnt);
    end

    // drain the count, then one extra decrement at zero
    for (int k = 0; k <= 60; k++) begin
      @(negedge clk); pkt_dec = 1'b1;
      @(negedge clk); pkt_dec = 1'b0;
    end
    exp_cnt = 0;
    chk(pkt_count == 8'd0, "R8 decrement floor", int'(pkt_count), 0);

    // room sweep around the tail
    for (int d = 0; d <= 20; d += 2) begin
      for (int v = 0; v < 2; v++) begin
        len = (d >= 9) ? d - 8 + v : 1 + v;
        dd = d;
        tail = AW'(wadd(exp_head, dd));
        bmem[wadd(exp_head, dd)] = 8'hA5;
        h0 = exp_head; d0 = ndrop;
        expd = (8 + len > dd);
        send(len, 99 + d, 1'b0);
        chk(bmem[wadd(h0, dd)] == 8'hA5, "R6 tail byte untouched",
            int'(bmem[wadd(h0, dd)]), 'hA5);
        chk((ndrop - d0) == int'(expd), "R6 drop pulse", ndrop - d0, int'(expd));
        if (expd) begin
          chk(int'(head) == h0, "R6 head restored", int'(head), h0);
        end else begin
          check_stored(h0, len, 99 + d);
          exp_cnt++;
          chk(int'(head) == exp_head, "R4 head exact fit", int'(head), exp_head);
        end
        chk(int'(pkt_count) == exp_cnt, "R6 count", int'(pkt_count), exp_cnt);
      end
    end

    // reception disabled
    tail = AW'(wsub2(exp_head));
    rx_enable = 1'b0; w0 = nwr; d0 = ndrop; h0 = exp_head;
    send(5, 3, 1'b0);
    chk(nwr == w0 && ndrop == d0 && int'(head) == h0, "R9 disabled ignored",
        nwr - w0, 0);
    rx_enable = 1'b1;

    // bytes during header cycles
    w0 = nwr; d0 = ndrop; h0 = exp_head;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (j == 0); in_eof = (j == 2);
      in_data = pat(7, j); in_err = 1'b1; in_status = stv(3);
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == 7); in_data = 8'hEE;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    exp_cnt++;
    chk(nwr - w0 == 11, "R10 writes during header", nwr - w0, 11);
    chk(ndrop == d0, "R10 no drop", ndrop - d0, 0);
    check_stored(h0, 3, 7);
    chk(int'(head) == exp_head && int'(pkt_count) == exp_cnt, "R10 commit",
        int'(pkt_count), exp_cnt);

    // saturate the count
    while (exp_cnt < 255) begin
      tail = AW'(wsub2(exp_head));
      send(2, exp_cnt, 1'b0);
      exp_head = wadd(exp_head, 10);
      exp_cnt++;
    end
    chk(pkt_count == 8'd255, "R8 count reaches 255", int'(pkt_count), 255);
    tail = AW'(wsub2(exp_head));
    h0 = exp_head; d0 = ndrop; c0 = exp_cnt;
    send(4, 1, 1'b0);
    chk(ndrop - d0 == 1, "R7 drop at full count", ndrop - d0, 1);
    chk(pkt_count == 8'd255 && int'(head) == h0, "R7 count and head kept",
        int'(head), h0);
    @(negedge clk); pkt_dec = 1'b1;
    @(negedge clk); pkt_dec = 1'b0;
    chk(pkt_count == 8'd254, "R8 decrement from full", int'(pkt_count), 254);

    // decrement on the commit edge
    h0 = exp_head;
    send(6, 77, 1'b1);
    check_stored(h0, 6, 77);
    chk(pkt_count == 8'd254, "R8 commit with decrement", int'(pkt_count), 254);
    chk(int'(head) == exp_head, "R4 head with decrement", int'(head), exp_head);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule